// File: doc/BRIEF.md
# Amplifier Control Register Port

This block is the write-only command port of an audio amplifier. It accepts command bytes from one of two serial front ends: a two-wire bus with start/stop framing, an address byte and an acknowledge, or a three-wire bus with an active-low frame enable, a shift clock and a data line. A static select input chooses which front end is heard. All serial pins are brought into the system clock through two-flop samplers. Edges are then found by comparing successive synchronised samples.

Every accepted byte goes to one shared register file, and its high-order bits pick the target register. A mode byte carries the mute and shutdown controls. A volume byte carries a 5-bit gain code. Any other byte is dropped. Both control bits are active at 0, and reset leaves the amplifier muted and shut down.

The two-wire receiver has five states:
- I_IDLE is left only on a start.
- I_ADDR shifts in eight bits. On the falling clock after the eighth bit it goes to I_ADDR_ACK if the byte matches, and back to I_IDLE if it does not.
- I_ADDR_ACK goes to I_DATA at the next falling clock.
- I_DATA goes to I_DATA_ACK after eight bits and hands the byte over.
- I_DATA_ACK returns to I_DATA.
- From any state, a start goes to I_ADDR and a stop goes to I_IDLE.

The three-wire receiver has three states:
- S_IDLE goes to S_SHIFT when the enable is low.
- S_SHIFT goes to S_DONE on the eighth rising clock and hands the byte over. It returns to S_IDLE if the enable rises first.
- S_DONE ignores further clocks and returns to S_IDLE when the enable rises.

Top module: `amp_ctrl_port`

## Requirements
- R1: With `mode_spi`=0 only the two-wire port is heard; with `mode_spi`=1 only the three-wire port is heard and `sda_pull_o` stays 0.
- R2: The two-wire address byte, MSB first, is 1,1,0,1,1,0,`addr_strap`,0. On a match, `sda_pull_o` pulls the line low during the following acknowledge clock.
- R3: Any other address byte, including the read form ending in 1, gets no acknowledge. The bytes after it are neither acknowledged nor applied until the next start.
- R4: After one matching address, any number of data bytes are each acknowledged and applied until a stop. Bits clocked after a stop and without a new start are ignored.
- R5: In three-wire mode, data is sampled on rising `spi_clk_i` while `spi_en_n_i` is low, MSB first. The byte is applied after the eighth rising clock.
- R6: If `spi_en_n_i` rises before eight clocks, the partial byte is discarded, and the next frame starts with a clean count.
- R7: Clocks beyond the eighth within one enable-low frame are ignored.
- R8: A byte with bit7=0 and bit5=0 loads `mute_bit_o` from bit1 and `shdn_bit_o` from bit0, with 0 meaning active. The volume is unchanged.
- R9: A byte with bits 7..5 = 100 loads `vol_code_o` from bits 4..0. Mute and shutdown are unchanged.
- R10: A byte matching neither prefix (bit7=0 with bit5=1, or bit7=1 with bit6 or bit5 set) changes no output.
- R11: After reset, `mute_bit_o`=0, `shdn_bit_o`=0, `vol_code_o`=0 and `sda_pull_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_spi | input | 1 | Front-end select: 0 two-wire, 1 three-wire |
| addr_strap | input | 1 | Address bit 1 of the two-wire address byte |
| scl_i | input | 1 | Two-wire clock |
| sda_i | input | 1 | Two-wire data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls the two-wire data line low (acknowledge) |
| spi_en_n_i | input | 1 | Three-wire frame enable, active low |
| spi_clk_i | input | 1 | Three-wire shift clock |
| spi_dat_i | input | 1 | Three-wire serial data |
| mute_bit_o | output | 1 | Mute control, 0 = muted |
| shdn_bit_o | output | 1 | Shutdown control, 0 = shut down |
| vol_code_o | output | 5 | Volume code |

## Verification
A pin edge reaches the second sampler flop at the second system clock edge. The receiver registers its byte strobe at the third edge, and the outputs change at the fourth. The acknowledge pull follows the detected falling clock by one further edge. The bench holds every serial half-period for eight system clocks and samples outputs on falling system clock edges at least six cycles after the last serial edge of a byte. It samples the acknowledge in the middle of the acknowledge clock's high phase, well after both latencies have elapsed. The three-wire sweep applies all 256 byte values, each against a register model computed in the bench.

// File: rtl/ampctl_pkg.sv
package ampctl_pkg;
    localparam int BYTE_W = 8;
    localparam int VOL_W  = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        I_IDLE, I_ADDR, I_ADDR_ACK, I_DATA, I_DATA_ACK
    } i2c_st_e;

    typedef enum logic [1:0] {
        S_IDLE, S_SHIFT, S_DONE
    } spi_st_e;

    typedef enum logic [1:0] {
        CMD_MODE, CMD_VOL, CMD_NONE
    } cmd_e;

    function automatic cmd_e classify(input byte_t b);
        if (!b[7] && !b[5])          return CMD_MODE;
        else if (b[7:5] == 3'b100)   return CMD_VOL;
        else                         return CMD_NONE;
    endfunction
endpackage

// File: rtl/ampctl_sync.sv
module ampctl_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ampctl_i2c_rx.sv
module ampctl_i2c_rx
    import ampctl_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b110110
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl,
    input  logic  sda,
    input  logic  adr,
    output logic  pull,
    output byte_t byte_o,
    output logic  stb
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    i2c_st_e    st, nxt;
    logic       scl_q, sda_q;
    logic [CNT_W-1:0] cnt;
    byte_t      shreg;
    byte_t      addr_exp;

    assign addr_exp = {ADDR_HI, adr, 1'b0};

    wire scl_rise = scl & ~scl_q;
    wire scl_fall = ~scl & scl_q;
    wire start_c  = scl & scl_q & sda_q & ~sda;
    wire stop_c   = scl & scl_q & ~sda_q & sda;
    wire full     = (cnt == CNT_W'(BYTE_W));

    always_comb begin
        nxt = st;
        if (start_c)      nxt = I_ADDR;
        else if (stop_c)  nxt = I_IDLE;
        else begin
            unique case (st)
                I_IDLE:     nxt = I_IDLE;
                I_ADDR:     if (scl_fall && full)
                                nxt = (shreg == addr_exp) ? I_ADDR_ACK : I_IDLE;
                I_ADDR_ACK: if (scl_fall) nxt = I_DATA;
                I_DATA:     if (scl_fall && full) nxt = I_DATA_ACK;
                I_DATA_ACK: if (scl_fall) nxt = I_DATA;
                default:    nxt = I_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
            byte_o <= '0;
            stb    <= 1'b0;
            pull   <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            stb   <= 1'b0;
            pull  <= (nxt == I_ADDR_ACK) || (nxt == I_DATA_ACK);
            if (start_c || stop_c) begin
                cnt <= '0;
            end else if (scl_rise && (st == I_ADDR || st == I_DATA) && !full) begin
                shreg <= {shreg[BYTE_W-2:0], sda};
                cnt   <= cnt + 1'b1;
            end
            if (nxt == I_DATA && st != I_DATA) cnt <= '0;
            if (st == I_DATA && nxt == I_DATA_ACK) begin
                byte_o <= shreg;
                stb    <= 1'b1;
            end
        end
    end

    AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pull |-> (st == I_ADDR_ACK || st == I_DATA_ACK)); // R2
    AST_DATA_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R4
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_IDLE) |-> !pull); // R3
endmodule

// File: rtl/ampctl_spi_rx.sv
module ampctl_spi_rx
    import ampctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_n,
    input  logic  sck,
    input  logic  dat,
    output byte_t byte_o,
    output logic  stb
);
    localparam int CNT_W = $clog2(BYTE_W);

    spi_st_e          st, nxt;
    logic             sck_q;
    logic [CNT_W-1:0] cnt;
    byte_t            shreg;

    wire sck_rise = sck & ~sck_q;
    wire last_bit = (cnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (!en_n) nxt = S_SHIFT;
            S_SHIFT: if (en_n) nxt = S_IDLE;
                     else if (sck_rise && last_bit) nxt = S_DONE;
            S_DONE:  if (en_n) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            byte_o <= '0;
            stb    <= 1'b0;
        end else begin
            sck_q <= sck;
            stb   <= 1'b0;
            if (st == S_IDLE) cnt <= '0;
            if (st == S_SHIFT && !en_n && sck_rise) begin
                shreg <= {shreg[BYTE_W-2:0], dat};
                cnt   <= cnt + 1'b1;
                if (last_bit) begin
                    byte_o <= {shreg[BYTE_W-2:0], dat};
                    stb    <= 1'b1;
                end
            end
        end
    end

    AST_SPI_STB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (st == S_DONE)); // R7
    AST_SPI_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT && en_n) |=> !stb); // R6
    AST_SPI_DONE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE && $past(st) == S_DONE) |-> !stb); // R7
endmodule

// File: rtl/ampctl_regs.sv
module ampctl_regs
    import ampctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  byte_t            byte_i,
    input  logic             stb_i,
    output logic             mute_o,
    output logic             shdn_o,
    output logic [VOL_W-1:0] vol_o
);
    cmd_e cls;
    assign cls = classify(byte_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_o <= 1'b0;
            shdn_o <= 1'b0;
            vol_o  <= '0;
        end else if (stb_i) begin
            unique case (cls)
                CMD_MODE: begin
                    mute_o <= byte_i[1];
                    shdn_o <= byte_i[0];
                end
                CMD_VOL:  vol_o <= byte_i[VOL_W-1:0];
                CMD_NONE: ;
                default:  ;
            endcase
        end
    end

    AST_VOL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cls == CMD_VOL) |=> $stable({mute_o, shdn_o})); // R9
    AST_MODE_KEEPS_VOL: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cls == CMD_MODE) |=> $stable(vol_o)); // R8
    AST_NONE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cls == CMD_NONE) |=> $stable({mute_o, shdn_o, vol_o})); // R10
endmodule

// File: rtl/amp_ctrl_port.sv
module amp_ctrl_port
    import ampctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_spi,
    input  logic             addr_strap,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             spi_en_n_i,
    input  logic             spi_clk_i,
    input  logic             spi_dat_i,
    output logic             mute_bit_o,
    output logic             shdn_bit_o,
    output logic [VOL_W-1:0] vol_code_o
);
    logic [1:0] tw_s;
    logic [2:0] sp_s;
    byte_t      tw_byte, sp_byte, cmd_byte;
    logic       tw_stb, sp_stb, cmd_stb, tw_pull;

    ampctl_sync #(.W(2), .INIT(2'b11)) u_sync_tw (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(tw_s));

    ampctl_sync #(.W(3), .INIT(3'b100)) u_sync_sp (
        .clk(clk), .rst_n(rst_n), .d({spi_en_n_i, spi_clk_i, spi_dat_i}), .q(sp_s));

    ampctl_i2c_rx u_tw (
        .clk(clk), .rst_n(rst_n), .scl(tw_s[1]), .sda(tw_s[0]), .adr(addr_strap),
        .pull(tw_pull), .byte_o(tw_byte), .stb(tw_stb));

    ampctl_spi_rx u_sp (
        .clk(clk), .rst_n(rst_n), .en_n(sp_s[2]), .sck(sp_s[1]), .dat(sp_s[0]),
        .byte_o(sp_byte), .stb(sp_stb));

    assign cmd_byte   = mode_spi ? sp_byte : tw_byte;
    assign cmd_stb    = mode_spi ? sp_stb  : tw_stb;
    assign sda_pull_o = tw_pull & ~mode_spi;

    ampctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .byte_i(cmd_byte), .stb_i(cmd_stb),
        .mute_o(mute_bit_o), .shdn_o(shdn_bit_o), .vol_o(vol_code_o));

    AST_SPI_MODE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_spi |-> !sda_pull_o); // R1
endmodule

// File: tb/amp_ctrl_port_tb.sv
module amp_ctrl_port_tb;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_spi = 1'b1, addr_strap = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic en_n = 1'b1, sck = 1'b0, dat = 1'b0;
    logic sda_pull, mute_b, shdn_b;
    logic [4:0] vol;
    logic sda_line;

    logic       em = 1'b0, es = 1'b0;
    logic [4:0] ev = 5'd0;
    int n_chk = 0, n_fail = 0;
    logic ackv;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    amp_ctrl_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi), .addr_strap(addr_strap),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .spi_en_n_i(en_n), .spi_clk_i(sck), .spi_dat_i(dat),
        .mute_bit_o(mute_b), .shdn_bit_o(shdn_b), .vol_code_o(vol));

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_out(input string tag);
        chk(tag, {mute_b, shdn_b, vol}, {em, es, ev});
    endtask

    task automatic model(input logic [7:0] b);
        if (!b[7] && !b[5]) begin em = b[1]; es = b[0]; end
        else if (b[7:5] == 3'b100) ev = b[4:0];
    endtask

    function automatic string tag_of(input logic [7:0] b);
        if (!b[7] && !b[5])        return "R8/R5";
        else if (b[7:5] == 3'b100) return "R9/R5";
        else                       return "R10/R5";
    endfunction

    task automatic spi_xfer(input logic [7:0] b, input int nbits);
        en_n = 1'b0; wc(H);
        for (int i = 0; i < nbits; i++) begin
            dat = (i < 8) ? b[7-i] : 1'b1;
            wc(H); sck = 1'b1; wc(H); sck = 1'b0;
        end
        wc(H); en_n = 1'b1; wc(H);
    endtask

    task automatic tw_start();
        sda_m = 1'b1; scl_m = 1'b1; wc(H);
        sda_m = 1'b0; wc(H);
        scl_m = 1'b0; wc(H);
    endtask

    task automatic tw_stop();
        sda_m = 1'b0; wc(H);
        scl_m = 1'b1; wc(H);
        sda_m = 1'b1; wc(H);
    endtask

    task automatic tw_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wc(H); scl_m = 1'b1; wc(H); scl_m = 1'b0; wc(2);
        end
        sda_m = 1'b1; wc(H); scl_m = 1'b1; wc(H/2);
        ack = ~sda_line;
        wc(H/2); scl_m = 1'b0; wc(2);
    endtask

    initial begin
        wc(5); rst_n = 1'b1; wc(4);
        chk_out("R11");
        chk("R11 sda released", {6'd0, sda_line}, 7'd1);

        // exhaustive three-wire sweep
        for (int v = 0; v < 256; v++) begin
            spi_xfer(8'(v), 8); model(8'(v)); wc(6);
            chk_out(tag_of(8'(v)));
        end

        // R6: aborted frame, then a clean frame
        spi_xfer(8'h95, 8); model(8'h95); wc(6);
        spi_xfer(8'h80, 5); wc(6);
        chk_out("R6 abort");
        spi_xfer(8'h83, 8); model(8'h83); wc(6);
        chk_out("R6 next frame");

        // R7: extra clocks in one frame
        spi_xfer(8'h8A, 12); model(8'h8A); wc(6);
        chk_out("R7 extra clocks");

        // R1: three-wire ignored in two-wire mode
        mode_spi = 1'b0; wc(4);
        spi_xfer(8'h9F, 8); wc(6);
        chk_out("R1 spi ignored");

        // R2 / R4 with strap 0
        addr_strap = 1'b0;
        tw_start();
        tw_byte(8'hD8, ackv); chk("R2 ack strap0", {6'd0, ackv}, 7'd1);
        tw_byte(8'h03, ackv); model(8'h03); chk("R4 ack data", {6'd0, ackv}, 7'd1);
        chk_out("R4 mode byte");
        for (int v = 0; v < 32; v++) begin
            tw_byte(8'h80 | 8'(v), ackv); model(8'h80 | 8'(v));
            chk("R4 ack vol", {6'd0, ackv}, 7'd1);
            chk_out("R9 two-wire vol");
        end
        tw_byte(8'h3F, ackv); chk_out("R10 two-wire none");
        tw_stop(); wc(4);
        chk_out("R4 after stop");

        // R2 / R3 with strap 1
        addr_strap = 1'b1;
        tw_start();
        tw_byte(8'hDA, ackv); chk("R2 ack strap1", {6'd0, ackv}, 7'd1);
        tw_byte(8'h01, ackv); model(8'h01); chk_out("R2 strap1 data");
        tw_stop();
        tw_start();
        tw_byte(8'hD8, ackv); chk("R3 wrong strap nack", {6'd0, ackv}, 7'd0);
        tw_byte(8'h00, ackv); chk("R3 data nack", {6'd0, ackv}, 7'd0);
        chk_out("R3 data ignored");
        tw_stop();
        tw_start();
        tw_byte(8'hDB, ackv); chk("R3 read form nack", {6'd0, ackv}, 7'd0);
        tw_stop();

        // R4: bits after stop without start
        tw_byte(8'hDA, ackv); chk("R4 no start nack", {6'd0, ackv}, 7'd0);
        tw_byte(8'h02, ackv); wc(4);
        chk_out("R4 no start ignored");

        // R1: two-wire ignored in three-wire mode
        mode_spi = 1'b1; wc(4);
        tw_start();
        tw_byte(8'hDA, ackv); chk("R1 no ack in spi mode", {6'd0, ackv}, 7'd0);
        tw_byte(8'h00, ackv);
        tw_stop(); wc(4);
        chk_out("R1 two-wire ignored");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule